// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one pulse-width command into the two gate enables of a half-bridge: a high-side enable and a low-side enable. The command arrives already decoded into three levels: high, low, and a mid-level shutdown window. Two comparator flags report when each gate's voltage has dropped below its off threshold. The sequencer never turns a gate on until the flag for the opposite gate confirms that gate is off. It then waits a fixed number of cycles before the turn-on. As a result, the dead time follows the real discharge of the gates instead of a fixed worst-case count.

When the command sits in the mid window, the sequencer first switches off whichever gate is on. If the command stays there longer than that gate's turn-off delay, the sequencer enters a shutdown state with both enables held low. A high or low command ends the shutdown and goes through the normal interlocked turn-on sequence. The four delays are elaboration parameters:
- low-side off delay
- high-side on delay
- high-side off delay
- low-side on delay

The states are:
- `S_IDLE`: after reset.
- `S_LO_ON` and `S_HI_ON`: conducting.
- `S_LO_OFF` and `S_HI_OFF`: the turn-off delay runs while the gate is still on.
- `S_WAIT_LO` and `S_WAIT_HI`: waiting for the named gate's low flag.
- `S_HI_DLY` and `S_LO_DLY`: the turn-on delay.
- `S_SHUT_OFF`: the mid-window timeout.
- `S_SHUT`: disabled.

The transitions are:
- rise: `S_LO_ON`→`S_LO_OFF`→`S_WAIT_LO`→`S_HI_DLY`→`S_HI_ON`.
- fall: `S_HI_ON`→`S_HI_OFF`→`S_WAIT_HI`→`S_LO_DLY`→`S_LO_ON`.
- abort: a reversed command in a wait or turn-on-delay state jumps to the opposite wait state. A reversed command in an off-delay state returns to its own on state.
- window entry: any active state goes to `S_SHUT_OFF`.
- timeout: `S_SHUT_OFF`→`S_SHUT`.
- restart: `S_IDLE`, `S_SHUT` or `S_SHUT_OFF` goes to `S_WAIT_LO` on a high command, or to `S_WAIT_HI` on a low command.

Top module: `gate_seq_top`

## Requirements
- R1: After reset both enables are 0 and status is idle (0). The block stays idle while the command is in the mid window, and leaves idle only on a valid level.
- R2: When a high command is first sampled while the low gate is on, the low enable stays 1 for T_OFF_LO more cycles and drops on the next one.
- R3: The high enable rises only after the low-gate-low flag has been sampled 1 in the wait state. It rises exactly T_ON_HI cycles after that sample, and the flag must stay 1 in between.
- R4: When a low command is first sampled while the high gate is on, the high enable stays 1 for T_OFF_HI more cycles and then drops.
- R5: The low enable rises only after the high-gate-low flag has been sampled 1 in the wait state. It rises exactly T_ON_LO cycles after that sample.
- R6: The high and low enables are never 1 in the same cycle.
- R7: In the cycle after a mid-window command is sampled, both enables are 0. The command encoding is 2'b00 low, 2'b01 high, and 2'b1x mid window.
- R8: The mid window must be sampled on D+2 consecutive edges to reach shutdown (status 4), where D is the off delay of the gate that conducted last. A shorter stay never reaches shutdown, and the sequence resumes.
- R9: From shutdown, a valid level starts the normal sequence. That level waits for the opposite gate's low flag and then for its on delay.
- R10: A delay parameter of 0 adds no cycles. The off and on phases each skip their counting state.
- R11: A reversed command during a flag wait abandons the wait and starts the sequence for the new command.
- R12: Status is 3 bits: 0 idle, 1 low gate on, 2 high gate on, 3 transitioning with both gates off, 4 shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_lvl | input | 2 | Decoded command: 00 low, 01 high, 1x mid window |
| lo_gate_low | input | 1 | Low-side gate voltage is below its off threshold |
| hi_gate_low | input | 1 | High-side gate voltage is below its off threshold |
| hi_gate_en | output | 1 | High-side gate enable |
| lo_gate_en | output | 1 | Low-side gate enable |
| seq_status | output | 3 | Sequencer status code |

## Verification
Directed edges under manually held comparator flags separate the four delay phases. A gate left reporting "high" shows that a turn-on really waits on the flag and not on a timer. Mid-window pulses one edge shorter and one edge longer than the timeout separate the turn-off from the shutdown. A reversed command during a stalled wait exposes the abort path, and a second instance with zero delays separates skipped phases from counted ones. Random command runs with lagging flag models then confirm that the enables never overlap, that every turn-on is preceded by enough flag-true cycles, and that steady commands always settle.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef enum logic [2:0] {
        STS_IDLE    = 3'd0,
        STS_LOW_ON  = 3'd1,
        STS_HIGH_ON = 3'd2,
        STS_TRANS   = 3'd3,
        STS_SHUT    = 3'd4
    } seq_status_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LO_ON,
        S_LO_OFF,
        S_WAIT_LO,
        S_HI_DLY,
        S_HI_ON,
        S_HI_OFF,
        S_WAIT_HI,
        S_LO_DLY,
        S_SHUT_OFF,
        S_SHUT
    } seq_state_t;

    typedef struct packed {
        logic go_hi;
        logic go_lo;
        logic hold_off;
    } cmd_t;

endpackage

// File: rtl/gs_cmd_decode.sv
module gs_cmd_decode
    import gate_seq_pkg::*;
(
    input  logic [1:0] pwm_lvl,
    output cmd_t       cmd
);
    always_comb begin
        cmd.hold_off = pwm_lvl[1];
        cmd.go_hi    = (pwm_lvl == 2'b01);
        cmd.go_lo    = (pwm_lvl == 2'b00);
    end
endmodule

// File: rtl/gs_dly_timer.sv
module gs_dly_timer #(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
    import gate_seq_pkg::*;
#(
    parameter int unsigned DLY_W    = 8,
    parameter int unsigned T_OFF_LO = 2,
    parameter int unsigned T_ON_HI  = 3,
    parameter int unsigned T_OFF_HI = 1,
    parameter int unsigned T_ON_LO  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic             lo_low,
    input  logic             hi_low,
    input  logic             tmr_zero,
    output seq_state_t       state_q,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val
);
    localparam logic [DLY_W-1:0] OFF_LO_FULL = DLY_W'(T_OFF_LO);
    localparam logic [DLY_W-1:0] OFF_HI_FULL = DLY_W'(T_OFF_HI);
    localparam logic [DLY_W-1:0] OFF_LO_M1   = DLY_W'((T_OFF_LO > 0) ? T_OFF_LO - 1 : 0);
    localparam logic [DLY_W-1:0] OFF_HI_M1   = DLY_W'((T_OFF_HI > 0) ? T_OFF_HI - 1 : 0);
    localparam logic [DLY_W-1:0] ON_HI_M1    = DLY_W'((T_ON_HI > 0) ? T_ON_HI - 1 : 0);
    localparam logic [DLY_W-1:0] ON_LO_M1    = DLY_W'((T_ON_LO > 0) ? T_ON_LO - 1 : 0);

    typedef struct packed {
        seq_state_t       st;
        logic             ld;
        logic [DLY_W-1:0] v;
    } step_t;

    seq_state_t state_d;
    logic       last_hi_q;
    step_t      stp;

    function automatic step_t go(input seq_state_t s);
        step_t r;
        r.st = s;
        r.ld = 1'b0;
        r.v  = '0;
        return r;
    endfunction

    function automatic step_t go_ld(input seq_state_t s, input logic [DLY_W-1:0] v);
        step_t r;
        r.st = s;
        r.ld = 1'b1;
        r.v  = v;
        return r;
    endfunction

    // Start the turn-off phase of the low gate, skipped when its delay is zero
    function automatic step_t begin_lo_off();
        if (T_OFF_LO > 0) return go_ld(S_LO_OFF, OFF_LO_M1);
        return go(S_WAIT_LO);
    endfunction

    function automatic step_t begin_hi_off();
        if (T_OFF_HI > 0) return go_ld(S_HI_OFF, OFF_HI_M1);
        return go(S_WAIT_HI);
    endfunction

    function automatic step_t begin_hi_on();
        if (T_ON_HI > 0) return go_ld(S_HI_DLY, ON_HI_M1);
        return go(S_HI_ON);
    endfunction

    function automatic step_t begin_lo_on();
        if (T_ON_LO > 0) return go_ld(S_LO_DLY, ON_LO_M1);
        return go(S_LO_ON);
    endfunction

    function automatic step_t begin_shut(input logic from_hi);
        return go_ld(S_SHUT_OFF, from_hi ? OFF_HI_FULL : OFF_LO_FULL);
    endfunction

    always_comb begin
        stp = go(state_q);
        unique case (state_q)
            S_IDLE, S_SHUT: begin
                if (cmd.go_hi)      stp = go(S_WAIT_LO);
                else if (cmd.go_lo) stp = go(S_WAIT_HI);
            end
            S_LO_ON: begin
                if (cmd.hold_off)   stp = begin_shut(1'b0);
                else if (cmd.go_hi) stp = begin_lo_off();
            end
            S_LO_OFF: begin
                if (cmd.hold_off)              stp = begin_shut(1'b0);
                else if (cmd.go_lo)            stp = go(S_LO_ON);
                else if (tmr_zero)             stp = go(S_WAIT_LO);
            end
            S_WAIT_LO: begin
                if (cmd.hold_off)              stp = begin_shut(last_hi_q);
                else if (cmd.go_lo)            stp = go(S_WAIT_HI);
                else if (lo_low)               stp = begin_hi_on();
            end
            S_HI_DLY: begin
                if (cmd.hold_off)              stp = begin_shut(last_hi_q);
                else if (cmd.go_lo)            stp = go(S_WAIT_HI);
                else if (tmr_zero)             stp = go(S_HI_ON);
            end
            S_HI_ON: begin
                if (cmd.hold_off)   stp = begin_shut(1'b1);
                else if (cmd.go_lo) stp = begin_hi_off();
            end
            S_HI_OFF: begin
                if (cmd.hold_off)              stp = begin_shut(1'b1);
                else if (cmd.go_hi)            stp = go(S_HI_ON);
                else if (tmr_zero)             stp = go(S_WAIT_HI);
            end
            S_WAIT_HI: begin
                if (cmd.hold_off)              stp = begin_shut(last_hi_q);
                else if (cmd.go_hi)            stp = go(S_WAIT_LO);
                else if (hi_low)               stp = begin_lo_on();
            end
            S_LO_DLY: begin
                if (cmd.hold_off)              stp = begin_shut(last_hi_q);
                else if (cmd.go_hi)            stp = go(S_WAIT_LO);
                else if (tmr_zero)             stp = go(S_LO_ON);
            end
            S_SHUT_OFF: begin
                if (cmd.go_hi)                 stp = go(S_WAIT_LO);
                else if (cmd.go_lo)            stp = go(S_WAIT_HI);
                else if (tmr_zero)             stp = go(S_SHUT);
            end
            default: stp = go(S_IDLE);
        endcase
    end

    assign state_d  = stp.st;
    assign tmr_load = stp.ld;
    assign tmr_val  = stp.v;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            last_hi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_HI_ON)      last_hi_q <= 1'b1;
            else if (state_q == S_LO_ON) last_hi_q <= 1'b0;
        end
    end

    AST_HI_DLY_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {S_HI_DLY, S_HI_ON} && $past(state_q) == S_WAIT_LO) |-> $past(lo_low)); // R3
    AST_LO_DLY_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {S_LO_DLY, S_LO_ON} && $past(state_q) == S_WAIT_HI) |-> $past(hi_low)); // R5
    AST_IDLE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == S_IDLE && state_q != S_IDLE) |-> $past(cmd.go_hi || cmd.go_lo)); // R1
    AST_SHUT_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SHUT && $past(state_q) != S_SHUT) |-> $past(cmd.hold_off)); // R8
endmodule

// File: rtl/gs_gate_out.sv
module gs_gate_out
    import gate_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seq_state_t  state_q,
    output logic        hi_en,
    output logic        lo_en,
    output logic [2:0]  status
);
    seq_status_t sts;

    always_comb begin
        hi_en = 1'b0;
        lo_en = 1'b0;
        sts   = STS_TRANS;
        unique case (state_q)
            S_IDLE:            sts = STS_IDLE;
            S_LO_ON, S_LO_OFF: begin lo_en = 1'b1; sts = STS_LOW_ON;  end
            S_HI_ON, S_HI_OFF: begin hi_en = 1'b1; sts = STS_HIGH_ON; end
            S_SHUT:            sts = STS_SHUT;
            default:           sts = STS_TRANS;
        endcase
    end

    assign status = sts;

    AST_NO_OVERLAP:   assert property (@(posedge clk) disable iff (rst) !(hi_en && lo_en)); // R6
    AST_HI_RISE_GAP:  assert property (@(posedge clk) disable iff (rst) $rose(hi_en) |-> !$past(lo_en)); // R3
    AST_LO_RISE_GAP:  assert property (@(posedge clk) disable iff (rst) $rose(lo_en) |-> !$past(hi_en)); // R5
    AST_STATUS_HI:    assert property (@(posedge clk) disable iff (rst) hi_en |-> status == STS_HIGH_ON); // R12
    AST_STATUS_LO:    assert property (@(posedge clk) disable iff (rst) lo_en |-> status == STS_LOW_ON); // R12
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
    import gate_seq_pkg::*;
#(
    parameter int unsigned DLY_W    = 8,
    parameter int unsigned T_OFF_LO = 2,
    parameter int unsigned T_ON_HI  = 3,
    parameter int unsigned T_OFF_HI = 1,
    parameter int unsigned T_ON_LO  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwm_lvl,
    input  logic       lo_gate_low,
    input  logic       hi_gate_low,
    output logic       hi_gate_en,
    output logic       lo_gate_en,
    output logic [2:0] seq_status
);
    cmd_t             cmd;
    seq_state_t       state_q;
    logic             tmr_load;
    logic             tmr_zero;
    logic [DLY_W-1:0] tmr_val;

    gs_cmd_decode u_dec (
        .pwm_lvl (pwm_lvl),
        .cmd     (cmd)
    );

    gs_dly_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    gs_seq_fsm #(
        .DLY_W    (DLY_W),
        .T_OFF_LO (T_OFF_LO),
        .T_ON_HI  (T_ON_HI),
        .T_OFF_HI (T_OFF_HI),
        .T_ON_LO  (T_ON_LO)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .lo_low   (lo_gate_low),
        .hi_low   (hi_gate_low),
        .tmr_zero (tmr_zero),
        .state_q  (state_q),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    gs_gate_out u_out (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .hi_en   (hi_gate_en),
        .lo_en   (lo_gate_en),
        .status  (seq_status)
    );

    AST_MID_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd.hold_off |=> (!hi_gate_en && !lo_gate_en)); // R7
endmodule

// File: tb/test_gate_seq_top.sv
module test_gate_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_OFF_LO = 2;
    localparam int T_ON_HI  = 3;
    localparam int T_OFF_HI = 1;
    localparam int T_ON_LO  = 4;
    localparam int GLAG     = 2;
    localparam int SHUT_RUN = ((T_OFF_LO > T_OFF_HI) ? T_OFF_LO : T_OFF_HI) + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] pwm = 2'b10;
    logic [1:0] pwm_z = 2'b10;
    logic man_en = 1'b1, man_lo = 1'b0, man_hi = 1'b1;
    logic lo_low, hi_low;
    logic hi_en, lo_en, hi_z, lo_z;
    logic [2:0] st, st_z;
    int n_cmp = 0, n_bad = 0;
    logic chk_en = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_seq_top #(.T_OFF_LO(T_OFF_LO), .T_ON_HI(T_ON_HI), .T_OFF_HI(T_OFF_HI), .T_ON_LO(T_ON_LO))
    i_gate_seq_top (
        .clk(clk), .rst(rst), .pwm_lvl(pwm), .lo_gate_low(lo_low), .hi_gate_low(hi_low),
        .hi_gate_en(hi_en), .lo_gate_en(lo_en), .seq_status(st));

    gate_seq_top #(.T_OFF_LO(0), .T_ON_HI(0), .T_OFF_HI(0), .T_ON_LO(0))
    i_gate_seq_top_z (
        .clk(clk), .rst(rst), .pwm_lvl(pwm_z), .lo_gate_low(1'b1), .hi_gate_low(1'b1),
        .hi_gate_en(hi_z), .lo_gate_en(lo_z), .seq_status(st_z));

    // Gate voltage models: flag goes true GLAG edges after the enable drops
    int lo_off_cnt = 0, hi_off_cnt = 0;
    always_ff @(posedge clk) begin
        lo_off_cnt <= lo_en ? 0 : ((lo_off_cnt < GLAG) ? lo_off_cnt + 1 : lo_off_cnt);
        hi_off_cnt <= hi_en ? 0 : ((hi_off_cnt < GLAG) ? hi_off_cnt + 1 : hi_off_cnt);
    end
    always_comb begin
        lo_low = man_en ? man_lo : (lo_off_cnt >= GLAG);
        hi_low = man_en ? man_hi : (hi_off_cnt >= GLAG);
    end

    // Runs of sampled conditions, counted at the edges the design sees
    int mid_run = 0, high_run = 0, low_run = 0, lo_flag_run = 0, hi_flag_run = 0;
    always_ff @(posedge clk) begin
        mid_run     <= pwm[1] ? mid_run + 1 : 0;
        high_run    <= (pwm == 2'b01) ? high_run + 1 : 0;
        low_run     <= (pwm == 2'b00) ? low_run + 1 : 0;
        lo_flag_run <= lo_low ? lo_flag_run + 1 : 0;
        hi_flag_run <= hi_low ? hi_flag_run + 1 : 0;
    end

    function automatic bit turn_on_ok(input int flag_run, input int dly);
        return flag_run >= dly + 1;
    endfunction

    function automatic logic [2:0] status_for_gates(input logic h, input logic l);
        if (h) return 3'd2;
        if (l) return 3'd1;
        return 3'd3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Random-phase invariant checker
    logic hi_prev = 1'b0, lo_prev = 1'b0;
    always @(negedge clk) begin
        if (chk_en) begin
            check(!(hi_en && lo_en), "R6 overlap", {hi_en, lo_en}, 0);
            if (hi_en && !hi_prev)
                check(turn_on_ok(lo_flag_run, T_ON_HI), "R3 flag before high on", lo_flag_run, T_ON_HI + 1);
            if (lo_en && !lo_prev)
                check(turn_on_ok(hi_flag_run, T_ON_LO), "R5 flag before low on", hi_flag_run, T_ON_LO + 1);
            if (mid_run >= 1)
                check(!hi_en && !lo_en, "R7 window clears", {hi_en, lo_en}, 0);
            if (mid_run >= SHUT_RUN)
                check(st == 3'd4, "R8 shutdown reached", st, 4);
            else if (hi_en || lo_en || st == 3'd3)
                check(st == status_for_gates(hi_en, lo_en), "R12 status code", st, status_for_gates(hi_en, lo_en));
            if (high_run >= 16) check(hi_en, "R3 high settles", hi_en, 1);
            if (low_run >= 16)  check(lo_en, "R5 low settles", lo_en, 1);
        end
        hi_prev <= hi_en;
        lo_prev <= lo_en;
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        bit no_shut;
        void'($urandom(32'd4242));
        // R1 reset state and idle hold under mid window
        tick(3);
        check(!hi_en && !lo_en, "R1 reset enables", {hi_en, lo_en}, 0);
        check(st == 3'd0, "R1 reset status", st, 0);
        rst = 1'b0;
        tick(4);
        check(st == 3'd0 && !hi_en && !lo_en, "R1 idle under window", st, 0);

        // R10 zero-delay instance
        pwm_z = 2'b00;
        tick(1); check(!lo_z, "R10 zero low wait", lo_z, 0);
        tick(1); check(lo_z, "R10 zero low on", lo_z, 1);
        pwm_z = 2'b01;
        tick(1); check(!lo_z && !hi_z, "R10 zero off phase", {hi_z, lo_z}, 0);
        tick(1); check(hi_z, "R10 zero high on", hi_z, 1);
        pwm_z = 2'b10;
        tick(1); check(st_z == 3'd3, "R10 zero window timer", st_z, 3);
        tick(1); check(st_z == 3'd4, "R10 zero shutdown", st_z, 4);

        // R5 first turn-on from idle
        man_hi = 1'b1; man_lo = 1'b0;
        pwm = 2'b00;
        tick(1); check(st == 3'd3, "R12 leaving idle", st, 3);
        tick(4); check(!lo_en, "R5 low delay", lo_en, 0);
        tick(1); check(lo_en && st == 3'd1, "R5 low on", lo_en, 1);

        // R2 / R3 rising command
        pwm = 2'b01;
        tick(2); check(lo_en, "R2 low held", lo_en, 1);
        tick(1); check(!lo_en && !hi_en, "R2 low dropped", {hi_en, lo_en}, 0);
        tick(5); check(!hi_en, "R3 waits for flag", hi_en, 0);
        man_lo = 1'b1;
        tick(3); check(!hi_en, "R3 on delay", hi_en, 0);
        tick(1); check(hi_en && st == 3'd2, "R3 high on", hi_en, 1);

        // R4 / R5 falling command
        man_hi = 1'b0;
        pwm = 2'b00;
        tick(1); check(hi_en, "R4 high held", hi_en, 1);
        tick(1); check(!hi_en, "R4 high dropped", hi_en, 0);
        tick(4); check(!lo_en, "R5 waits for flag", lo_en, 0);
        man_hi = 1'b1;
        tick(4); check(!lo_en, "R5 on delay", lo_en, 0);
        tick(1); check(lo_en, "R5 low on again", lo_en, 1);

        // R7 / R8 long window from low gate
        pwm = 2'b10;
        tick(1); check(!lo_en && !hi_en && st == 3'd3, "R7 gate cleared", {hi_en, lo_en}, 0);
        tick(2); check(st == 3'd3, "R8 before timeout", st, 3);
        tick(1); check(st == 3'd4 && !hi_en && !lo_en, "R8 shutdown", st, 4);

        // R9 leaving shutdown
        pwm = 2'b01;
        tick(4); check(!hi_en && !lo_en, "R9 sequence from shutdown", {hi_en, lo_en}, 0);
        tick(1); check(hi_en, "R9 high on", hi_en, 1);

        // R8 short window from high gate
        pwm = 2'b11;
        tick(1); check(!hi_en, "R7 high cleared", hi_en, 0);
        tick(1); check(st == 3'd3, "R8 short window", st, 3);
        pwm = 2'b01;
        no_shut = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (st == 3'd4) no_shut = 1'b0;
        end
        check(no_shut, "R8 no shutdown", no_shut, 1);
        check(hi_en, "R8 resumed", hi_en, 1);

        // R11 abort a stalled wait
        man_hi = 1'b0;
        pwm = 2'b00;
        tick(4); check(!hi_en && !lo_en, "R11 stalled wait", {hi_en, lo_en}, 0);
        pwm = 2'b01;
        tick(4); check(!hi_en && !lo_en, "R11 new sequence", {hi_en, lo_en}, 0);
        tick(1); check(hi_en, "R11 high after abort", hi_en, 1);

        // Random phase with lagging gate models
        man_en = 1'b0;
        man_hi = 1'b1;
        tick(2);
        chk_en = 1'b1;
        for (int seg = 0; seg < 300; seg++) begin
            int pick, hold;
            pick = int'($urandom % 5);
            hold = 1 + int'($urandom % 24);
            pwm  = (pick < 2) ? 2'b01 : (pick < 4) ? 2'b00 : 2'(2 + ($urandom % 2));
            tick(hold);
        end
        chk_en = 1'b0;
        tick(2);
        summary();
    end
endmodule